// File: doc/BRIEF.md
# Single-Cycle Clock Glitch Generator

This block derives a target clock from a fast reference clock. Each target cycle lasts a programmable number of reference ticks. After a trigger, exactly one selected cycle is shortened by an adjustable amount, called delta, so that only that cycle can break the setup time of the logic it clocks. Every other cycle keeps the nominal length. The block is used to place a timing fault in a chosen cycle of a device under test.

A built-in sweep controller runs a fault campaign. Delta starts at zero. Each trigger runs one trial. When a trial ends with no fault reported, delta grows by a fixed step for the next trial. The sweep ends at the first trial in which the device flags a fault, and the shortened cycle length of that trial is kept as the critical time. It also ends when delta has reached its ceiling without a fault. One reference tick stands for one delta step. With a step of 35 ps against a 10 ns period, the nominal period is about 286 ticks.

All lengths are counted in reference ticks. The configuration inputs must stay stable while a trial runs, and the nominal period must be at least 4.

Top module: `cycle_glitch_gen`

## Requirements
- R1: While reset is asserted, the outputs are in their reset state: clk_out low, busy low, delta 0, found low, exhausted low, crit_time 0.
- R2: Every output clock cycle other than the shortened one lasts exactly cfg_period ticks, measured from rising edge to rising edge.
- R3: In each cycle of length L, clk_out is high for min(floor(cfg_period/2), L-1) ticks and low for the remaining ticks. A shortened cycle therefore loses ticks from its low phase first.
- R4: Take a rising edge of trig that is captured while idle and before the sweep has ended. The cycle that begins at the (cfg_offset+1)-th cycle boundary after that capture lasts cfg_period - delta ticks.
- R5: busy rises on a captured trigger and stays high through the shortened cycle and one further nominal cycle. It falls at the end of that nominal cycle, which is the (cfg_offset+3)-th boundary after capture.
- R6: delta is 0 after reset. After a trial that ends with fault_in low, delta becomes min(delta + cfg_step, limit). Here limit is min(cfg_limit, cfg_period - 3).
- R7: If fault_in is high at the end of the nominal cycle that follows the shortened cycle, found is set and crit_time becomes cfg_period - delta. After that, delta, found and crit_time hold and further triggers start no trial.
- R8: A trial that ends with fault_in low while delta already equals the limit sets exhausted. After that, further triggers start no trial and delta holds.
- R9: Only a low-to-high change of trig starts a trial. A trigger edge that arrives while busy is ignored and does not move the shortened cycle.
- R10: fault_in has no effect while no trial is running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast reference clock; one tick is one delta step |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_period | input | PW | Nominal output period in ticks |
| cfg_offset | input | OW | Boundaries after trigger capture, minus one, before the shortened cycle |
| cfg_step | input | PW | Delta increment per fault-free trial |
| cfg_limit | input | PW | Ceiling for delta (also clamped to cfg_period - 3) |
| trig | input | 1 | Trial start request, rising edge sensitive, synchronised inside |
| fault_in | input | 1 | Fault flag from the device under test |
| clk_out | output | 1 | Generated target clock |
| busy | output | 1 | A trial is in progress |
| delta | output | PW | Current shortening amount in ticks |
| crit_time | output | PW | Cycle length in ticks of the first faulting trial |
| found | output | 1 | Sweep ended on a reported fault |
| exhausted | output | 1 | Sweep reached the delta ceiling with no fault |

## Verification
On every cycle, the embedded properties check the following. Delta never exceeds its effective ceiling and changes only at the end of a trial. found and exhausted are never both set, and once set they are sticky. busy can only rise after a detected trigger edge. The shortened cycle is entered only at a cycle boundary. Other behaviour is visible only in the bench's scenarios, which measure the clock at the ports. These include the exact tick length and high time of each cycle around a trial, the index of the shortened cycle for several offsets, the full delta sequence across a sweep, the critical time, clamping at the ceiling, and triggers ignored while busy or after the sweep has ended.

// File: rtl/cgg_pkg.sv
package cgg_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_ARMED  = 2'd1,
    ST_GLITCH = 2'd2,
    ST_SETTLE = 2'd3
  } trial_st_e;

endpackage

// File: rtl/cgg_rst_sync.sv
module cgg_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] shift_q;
  logic [STAGES-1:0] shift_d;

  always_comb begin
    shift_d = {shift_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) shift_q <= '0;
    else        shift_q <= shift_d;
  end

  assign rst_sync_n = shift_q[STAGES-1];

endmodule

// File: rtl/cgg_edge.sv
module cgg_edge #(
  parameter int SYNC = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic rise
);

  generate
    if (SYNC == 0) begin : g_direct
      logic prev_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= din;
      end
      assign rise = din & ~prev_q;
    end else begin : g_sync
      // bits [SYNC-1:0] synchronise, bit SYNC holds the previous value
      logic [SYNC:0] chain_q;
      logic [SYNC:0] chain_d;
      always_comb begin
        chain_d = {chain_q[SYNC-1:0], din};
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= chain_d;
      end
      assign rise = chain_q[SYNC-1] & ~chain_q[SYNC];
    end
  endgenerate

  // R9
  rise_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> !rise);

endmodule

// File: rtl/cgg_clkgen.sv
module cgg_clkgen #(
  parameter int PW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [PW-1:0] cyc_len,
  input  logic [PW-1:0] half,
  output logic          cyc_end,
  output logic          clk_out
);

  logic [PW-1:0] tick_q, tick_d;
  logic          out_q, out_d;

  always_comb begin
    cyc_end = (tick_q >= (cyc_len - PW'(1)));
    tick_d  = cyc_end ? '0 : (tick_q + PW'(1));
    out_d   = (tick_q < half) && !cyc_end;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tick_q <= '0;
      out_q  <= 1'b0;
    end else begin
      tick_q <= tick_d;
      out_q  <= out_d;
    end
  end

  assign clk_out = out_q;

  // R3
  rise_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(clk_out) |-> (tick_q == PW'(1)));

endmodule

// File: rtl/cgg_sweep.sv
module cgg_sweep
  import cgg_pkg::*;
#(
  parameter int PW = 12,
  parameter int OW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          trig_rise,
  input  logic          cyc_end,
  input  logic          fault_in,
  input  logic [PW-1:0] cfg_period,
  input  logic [OW-1:0] cfg_offset,
  input  logic [PW-1:0] cfg_step,
  input  logic [PW-1:0] cfg_limit,
  output logic [PW-1:0] cyc_len,
  output logic          busy,
  output logic [PW-1:0] delta,
  output logic [PW-1:0] crit,
  output logic          found,
  output logic          exhausted
);

  localparam logic [PW-1:0] MARGIN = PW'(3);

  trial_st_e     st_q, st_d;
  logic [OW-1:0] cnt_q, cnt_d;
  logic [PW-1:0] dl_q, dl_d;
  logic [PW-1:0] crit_q, crit_d;
  logic          found_q, found_d;
  logic          exh_q, exh_d;

  logic [PW-1:0] per_lim, lim_eff, dl_next;
  logic [PW:0]   dl_sum;

  always_comb begin
    per_lim = cfg_period - MARGIN;
    lim_eff = (cfg_limit > per_lim) ? per_lim : cfg_limit;
    dl_sum  = {1'b0, dl_q} + {1'b0, cfg_step};
    dl_next = (dl_sum > {1'b0, lim_eff}) ? lim_eff : dl_sum[PW-1:0];
  end

  always_comb begin
    st_d    = st_q;
    cnt_d   = cnt_q;
    dl_d    = dl_q;
    crit_d  = crit_q;
    found_d = found_q;
    exh_d   = exh_q;
    unique case (st_q)
      ST_IDLE: begin
        if (trig_rise && !found_q && !exh_q) begin
          st_d  = ST_ARMED;
          cnt_d = '0;
        end
      end
      ST_ARMED: begin
        if (cyc_end) begin
          if (cnt_q == cfg_offset) st_d  = ST_GLITCH;
          else                     cnt_d = cnt_q + OW'(1);
        end
      end
      ST_GLITCH: begin
        if (cyc_end) st_d = ST_SETTLE;
      end
      ST_SETTLE: begin
        if (cyc_end) begin
          st_d = ST_IDLE;
          if (fault_in) begin
            found_d = 1'b1;
            crit_d  = cfg_period - dl_q;
          end else if (dl_q >= lim_eff) begin
            exh_d = 1'b1;
          end else begin
            dl_d = dl_next;
          end
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      cnt_q   <= '0;
      dl_q    <= '0;
      crit_q  <= '0;
      found_q <= 1'b0;
      exh_q   <= 1'b0;
    end else begin
      st_q    <= st_d;
      cnt_q   <= cnt_d;
      dl_q    <= dl_d;
      crit_q  <= crit_d;
      found_q <= found_d;
      exh_q   <= exh_d;
    end
  end

  assign cyc_len   = (st_q == ST_GLITCH) ? (cfg_period - dl_q) : cfg_period;
  assign busy      = (st_q != ST_IDLE);
  assign delta     = dl_q;
  assign crit      = crit_q;
  assign found     = found_q;
  assign exhausted = exh_q;

  // R6
  delta_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dl_q <= lim_eff);

  // R6
  delta_when_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dl_q != $past(dl_q)) |-> ($past(st_q) == ST_SETTLE && $past(cyc_end)));

  // R7
  found_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    found_q |=> (found_q && $stable(dl_q) && $stable(crit_q)));

  // R8
  exh_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    exh_q |=> (exh_q && $stable(dl_q)));

  // R7
  flags_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(found_q && exh_q));

  // R5
  busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(trig_rise));

  // R4
  glitch_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_GLITCH && $past(st_q) == ST_ARMED) |-> $past(cyc_end));

endmodule

// File: rtl/cycle_glitch_gen.sv
module cycle_glitch_gen #(
  parameter int PW   = 12,
  parameter int OW   = 8,
  parameter int SYNC = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [PW-1:0] cfg_period,
  input  logic [OW-1:0] cfg_offset,
  input  logic [PW-1:0] cfg_step,
  input  logic [PW-1:0] cfg_limit,
  input  logic          trig,
  input  logic          fault_in,
  output logic          clk_out,
  output logic          busy,
  output logic [PW-1:0] delta,
  output logic [PW-1:0] crit_time,
  output logic          found,
  output logic          exhausted
);

  logic          rst_sync_n;
  logic          trig_rise;
  logic          cyc_end;
  logic [PW-1:0] cyc_len;
  logic [PW-1:0] half;

  assign half = cfg_period >> 1;

  cgg_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  cgg_edge #(.SYNC(SYNC)) u_edge (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .din   (trig),
    .rise  (trig_rise)
  );

  cgg_clkgen #(.PW(PW)) u_clkgen (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .cyc_len (cyc_len),
    .half    (half),
    .cyc_end (cyc_end),
    .clk_out (clk_out)
  );

  cgg_sweep #(.PW(PW), .OW(OW)) u_sweep (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .trig_rise  (trig_rise),
    .cyc_end    (cyc_end),
    .fault_in   (fault_in),
    .cfg_period (cfg_period),
    .cfg_offset (cfg_offset),
    .cfg_step   (cfg_step),
    .cfg_limit  (cfg_limit),
    .cyc_len    (cyc_len),
    .busy       (busy),
    .delta      (delta),
    .crit       (crit_time),
    .found      (found),
    .exhausted  (exhausted)
  );

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    !rst_sync_n |-> (!clk_out && !busy && !found && !exhausted));

endmodule

// File: tb/cycle_glitch_gen_tb.sv
`timescale 1ns/1ps
module cycle_glitch_gen_tb;

  localparam int PW = 12;
  localparam int OW = 8;
  localparam int SYNC = 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [PW-1:0] cfg_period = 12'd20;
  logic [OW-1:0] cfg_offset = '0;
  logic [PW-1:0] cfg_step = 12'd1;
  logic [PW-1:0] cfg_limit = 12'd10;
  logic          trig = 1'b0;
  logic          fault_in = 1'b0;
  logic          clk_out, busy, found, exhausted;
  logic [PW-1:0] delta, crit_time;

  always #2.5 clk = ~clk;

  cycle_glitch_gen #(.PW(PW), .OW(OW), .SYNC(SYNC)) u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_period(cfg_period), .cfg_offset(cfg_offset),
    .cfg_step(cfg_step), .cfg_limit(cfg_limit), .trig(trig), .fault_in(fault_in),
    .clk_out(clk_out), .busy(busy), .delta(delta), .crit_time(crit_time),
    .found(found), .exhausted(exhausted)
  );

  int n_chk = 0;
  int n_fail = 0;
  int edge_cnt = 0;
  bit finished = 0;

  bit trial_on = 0;
  int t_T, t_off, t_glen, t_per, t_half;
  bit t_busy;
  int ridx, last_rise, last_fall;
  logic clk_prev = 1'b0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int min2(input int a, input int b);
    return (a < b) ? a : b;
  endfunction

  always @(posedge clk) edge_cnt <= edge_cnt + 1;

  // Port monitor: measures every cycle of a trial window in ticks
  always @(negedge clk) begin
    if (clk_out && !clk_prev) begin
      if (trial_on && edge_cnt >= t_T + 2) begin
        ridx++;
        if (ridx >= 2) begin
          int exp_len;
          exp_len = (ridx == t_off + 2) ? t_glen : t_per;
          if (ridx == t_off + 2)
            chk(edge_cnt - last_rise == exp_len, "R4", "shortened length",
                edge_cnt - last_rise, exp_len);
          else
            chk(edge_cnt - last_rise == exp_len, "R2", "nominal length",
                edge_cnt - last_rise, exp_len);
          chk(last_fall - last_rise == min2(t_half, exp_len - 1), "R3", "high time",
              last_fall - last_rise, min2(t_half, exp_len - 1));
          chk(busy == (t_busy && ridx <= t_off + 2), "R5", "busy", busy,
              (t_busy && ridx <= t_off + 2));
        end
        if (ridx == t_off + 3) trial_on = 0;
      end
      last_rise = edge_cnt;
    end
    if (!clk_out && clk_prev) last_fall = edge_cnt;
    clk_prev = clk_out;
  end

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic run_trial(input int off, input bit flt, input int glen,
                           input bit exp_busy, input bit retrig);
    int guard;
    cfg_offset = OW'(off);
    fault_in   = flt;
    t_T    = edge_cnt + 1 + SYNC;
    t_off  = off;
    t_glen = glen;
    t_per  = int'(cfg_period);
    t_half = int'(cfg_period) / 2;
    t_busy = exp_busy;
    ridx   = 0;
    trial_on = 1;
    trig = 1'b1;
    tick(2);
    trig = 1'b0;
    if (retrig) begin  // R9: second edge while busy
      tick(2);
      trig = 1'b1;
      tick(2);
      trig = 1'b0;
    end
    guard = 0;
    while (trial_on && guard < 20000) begin
      tick(1);
      guard++;
    end
    if (trial_on) begin
      chk(0, "R5", "trial window timeout", guard, 0);
      trial_on = 0;
    end
    tick(1);
    fault_in = 1'b0;
  endtask

  task automatic campaign(input int p, input int stp, input int lim,
                          input int cm, input bit off0);
    int dm, effl, n, off;
    bit flt, done, is_found;
    rst_n = 1'b0;
    cfg_period = PW'(p);
    cfg_step   = PW'(stp);
    cfg_limit  = PW'(lim);
    tick(3);
    chk(clk_out == 0 && busy == 0, "R1", "clk_out/busy in reset", {clk_out, busy}, 0);
    chk(delta == 0 && crit_time == 0, "R1", "delta/crit in reset", delta + crit_time, 0);
    chk(found == 0 && exhausted == 0, "R1", "flags in reset", {found, exhausted}, 0);
    rst_n = 1'b1;
    tick(6);
    fault_in = 1'b1;  // R10: idle fault pulse
    tick(5);
    fault_in = 1'b0;
    tick(1);
    chk(found == 0 && delta == 0, "R10", "idle fault_in effect", {found, delta}, 0);

    dm = 0;
    effl = min2(lim, p - 3);
    done = 0;
    is_found = 0;
    n = 0;
    while (!done && n < 300) begin
      off = off0 ? 0 : int'($urandom % 4);
      flt = ((p - dm) <= cm);
      run_trial(off, flt, p - dm, 1, n == 1);
      if (flt) begin
        chk(found == 1, "R7", "found", found, 1);
        chk(crit_time == PW'(p - dm), "R7", "crit_time", crit_time, p - dm);
        done = 1;
        is_found = 1;
      end else if (dm >= effl) begin
        chk(exhausted == 1, "R8", "exhausted", exhausted, 1);
        done = 1;
      end else begin
        dm = min2(dm + stp, effl);
        chk(found == 0 && exhausted == 0, "R6", "flags mid sweep", {found, exhausted}, 0);
      end
      chk(delta == PW'(dm), "R6", "delta", delta, dm);
      n++;
    end
    // trigger after the sweep has ended must be ignored
    run_trial(0, 1'b1, p, 0, 0);
    if (is_found) begin
      chk(found == 1 && delta == PW'(dm), "R7", "post-sweep delta", delta, dm);
      chk(crit_time == PW'(p - dm), "R7", "post-sweep crit", crit_time, p - dm);
    end else begin
      chk(exhausted == 1 && found == 0 && delta == PW'(dm), "R8", "post-sweep delta",
          delta, dm);
    end
  endtask

  initial begin
    int seed;
    seed = $urandom(32'h5EED1);
    tick(2);
    // directed: realistic ratio, fault appears at delta 6
    campaign(286, 1, 200, 280, 0);
    // directed: ceiling clamp to period-3 and exhaustion
    campaign(20, 7, 100, 0, 0);
    // directed: fault on the very first trial, offset 0
    campaign(30, 2, 20, 40, 1);
    // random campaigns
    for (int i = 0; i < 6; i++) begin
      int p, stp, lim, cm;
      p   = 16 + int'($urandom % 25);
      stp = 1 + int'($urandom % 4);
      lim = 1 + int'($urandom % p);
      cm  = ($urandom % 3 == 0) ? 0 : (p - 1 - int'($urandom % (p / 2)));
      campaign(p, stp, lim, cm, 0);
    end
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(5.0 * 190000);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule